// File: doc/BRIEF.md
# Floating-Point Mantissa Rounding Unit

This unit rounds an unpacked floating-point mantissa that carries two extra low-order bits, a guard bit and a round bit. A separate sticky bit summarises everything shifted out below them. The unit discards the guard and round bits. It then uses those bits, the sticky bit, the operand sign and a 2-bit rounding mode to decide whether to add one at the new least significant bit. The carry from that increment runs through the whole retained mantissa.

The result is registered, so it appears one clock after the inputs. A carry out of the top retained bit appears in an extra output bit, which means the rounded value may equal 2.0. Renormalising that value and adjusting the exponent is left to the surrounding datapath.

Two flags accompany the result. One reports that an increment took place. The other reports that the input was not exactly representable.

Top module: `mant_rounder`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, `mant_o`, `rounded_up_o` and `inexact_o` become zero.
- R2: One clock after the inputs are presented, `mant_o` equals `mant_i` shifted right by two (bit 1 is guard, bit 0 is round, both dropped) plus one if `rounded_up_o` is set. The sticky input is not altered by the shift.
- R3: If guard, round and sticky are all zero, `rounded_up_o` and `inexact_o` are both 0 whatever the mode and sign.
- R4: In mode 0 (nearest, ties to even), no increment happens while guard is 0. With guard 1, an increment happens if round is 1, sticky is 1, or bit 2 of `mant_i` (the retained LSB) is 1.
- R5: Mode 1 (toward zero) never increments.
- R6: Mode 2 (toward plus infinity) increments a non-exact input only when `sign_i` is 0.
- R7: Mode 3 (toward minus infinity) increments a non-exact input only when `sign_i` is 1.
- R8: `inexact_o` is 1 whenever any of guard, round or sticky is 1, whether or not an increment happens.
- R9: The increment carries through every retained bit into the top bit of `mant_o`. An all-ones retained mantissa that is rounded up yields a 1 in bit MANT_W-2 and zeros below it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mant_i | input | MANT_W | Mantissa; bit 1 is guard, bit 0 is round |
| sticky_i | input | 1 | OR of all bits below the round bit |
| sign_i | input | 1 | Operand sign, 1 means negative |
| mode_i | input | 2 | 0 nearest-even, 1 toward zero, 2 toward +inf, 3 toward -inf |
| mant_o | output | MANT_W-1 | Rounded mantissa including the carry-out bit |
| rounded_up_o | output | 1 | An increment was applied |
| inexact_o | output | 1 | Input was not exact |

## Verification
The assertions assume that every input is settled and known at each rising edge once reset is released. They compare each output with the inputs sampled one edge earlier, and only after one edge has passed outside reset. The bench changes inputs only on falling edges and holds them for a full cycle. It samples the outputs at the following falling edge, so each check sees exactly one input set.

// File: rtl/mant_rounder.sv
module mant_rounder #(
  parameter int MANT_W = 66
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [MANT_W-1:0] mant_i,
  input  logic              sticky_i,
  input  logic              sign_i,
  input  logic [1:0]        mode_i,
  output logic [MANT_W-2:0] mant_o,
  output logic              rounded_up_o,
  output logic              inexact_o
);
  localparam int KEEP_W = MANT_W - 2;

  logic [KEEP_W-1:0] kept;
  logic              guard, rbit, exact, bump;
  logic [KEEP_W:0]   sum;
  logic              past_ok;

  assign kept  = mant_i[MANT_W-1:2];
  assign guard = mant_i[1];
  assign rbit  = mant_i[0];
  assign exact = !(guard | rbit | sticky_i);

  always_comb begin
    unique case (mode_i)
      2'd1:    bump = 1'b0;
      2'd2:    bump = !sign_i;
      2'd3:    bump = sign_i;
      default: bump = guard & (rbit | sticky_i | kept[0]);
    endcase
    if (exact) bump = 1'b0;
  end

  assign sum = {1'b0, kept} + {{KEEP_W{1'b0}}, bump};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mant_o       <= '0;
      rounded_up_o <= 1'b0;
      inexact_o    <= 1'b0;
      past_ok      <= 1'b0;
    end else begin
      mant_o       <= sum;
      rounded_up_o <= bump;
      inexact_o    <= !exact;
      past_ok      <= 1'b1;
    end
  end

  a_r1_reset: assert property (@(posedge clk)
    !rst_n |=> (mant_o == '0 && !rounded_up_o && !inexact_o));

  a_r2_shift: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |-> mant_o == ({1'b0, $past(mant_i[MANT_W-1:2])} + {{KEEP_W{1'b0}}, rounded_up_o}));

  a_r3_exact: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(mant_i[1:0]) == 2'b00 && !$past(sticky_i)) |-> (!rounded_up_o && !inexact_o));

  a_r4_guard_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(mode_i) == 2'd0 && !$past(mant_i[1])) |-> !rounded_up_o);

  a_r5_toward_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(mode_i) == 2'd1) |-> !rounded_up_o);

  a_r6_plus_inf: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(mode_i) == 2'd2 && $past(sign_i)) |-> !rounded_up_o);

  a_r7_minus_inf: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(mode_i) == 2'd3 && !$past(sign_i)) |-> !rounded_up_o);

  a_r8_up_implies_inexact: assert property (@(posedge clk) disable iff (!rst_n)
    rounded_up_o |-> inexact_o);
endmodule

// File: tb/test_mant_rounder.sv
module test_mant_rounder;
  localparam int W = 66;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [W-1:0] mant_i;
  logic         sticky_i, sign_i;
  logic [1:0]   mode_i;
  logic [W-2:0] mant_o;
  logic         rounded_up_o, inexact_o;
  int           checks = 0;
  int           errors = 0;

  always #10 clk = ~clk;

  mant_rounder #(.MANT_W(W)) i_mant_rounder (
    .clk(clk), .rst_n(rst_n), .mant_i(mant_i), .sticky_i(sticky_i),
    .sign_i(sign_i), .mode_i(mode_i), .mant_o(mant_o),
    .rounded_up_o(rounded_up_o), .inexact_o(inexact_o));

  task automatic check(input string req, input logic [W-2:0] em,
                       input logic eu, input logic ex);
    checks++;
    if (mant_o !== em || rounded_up_o !== eu || inexact_o !== ex) begin
      errors++;
      $display("FAIL %s: got mant=%h up=%b inx=%b, expected mant=%h up=%b inx=%b",
               req, mant_o, rounded_up_o, inexact_o, em, eu, ex);
    end
  endtask

  task automatic apply(input string req, input logic [W-3:0] keep, input logic g,
                       input logic r, input logic s, input logic sg,
                       input logic [1:0] md, input logic eu);
    logic ex;
    @(negedge clk);
    mant_i = {keep, g, r}; sticky_i = s; sign_i = sg; mode_i = md;
    ex = g | r | s;
    @(negedge clk);
    check(req, {1'b0, keep} + {{(W-2){1'b0}}, eu}, eu, ex);
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    mant_i = '1; sticky_i = 1'b1; sign_i = 1'b0; mode_i = 2'd2;
    @(negedge clk); @(negedge clk);
    check("R1 reset", '0, 1'b0, 1'b0);
    rst_n = 1'b1;
  endtask

  task automatic t_exact;
    for (int md = 0; md < 4; md++)
      apply("R3 exact", 64'h1234_5678_9abc_def1, 0, 0, 0, md[0], md[1:0], 1'b0);
  endtask

  task automatic t_nearest;
    apply("R4 guard clear", 64'h11, 0, 1, 1, 0, 2'd0, 1'b0);
    apply("R4 tie even", 64'h10, 1, 0, 0, 0, 2'd0, 1'b0);
    apply("R4 tie odd", 64'h11, 1, 0, 0, 1, 2'd0, 1'b1);
    apply("R4 round set", 64'h10, 1, 1, 0, 0, 2'd0, 1'b1);
    apply("R4 sticky set", 64'h10, 1, 0, 1, 1, 2'd0, 1'b1);
  endtask

  task automatic t_directed;
    apply("R5 toward zero", 64'hff, 1, 1, 1, 0, 2'd1, 1'b0);
    apply("R8 inexact no bump", 64'h3, 0, 0, 1, 1, 2'd1, 1'b0);
    apply("R6 plus pos", 64'h40, 0, 0, 1, 0, 2'd2, 1'b1);
    apply("R6 plus neg", 64'h40, 1, 1, 1, 1, 2'd2, 1'b0);
    apply("R7 minus neg", 64'h40, 0, 1, 0, 1, 2'd3, 1'b1);
    apply("R7 minus pos", 64'h40, 1, 0, 0, 0, 2'd3, 1'b0);
  endtask

  task automatic t_carry;
    apply("R9 full carry", {64{1'b1}}, 1, 1, 0, 0, 2'd0, 1'b1);
    checks++;
    if (mant_o !== {1'b1, 64'h0}) begin
      errors++;
      $display("FAIL R9: got %h expected %h", mant_o, {1'b1, 64'h0});
    end
    apply("R2 partial carry", 64'h0000_0000_ffff_ffff, 0, 1, 0, 1, 2'd3, 1'b1);
  endtask

  initial begin
    #(20 * 100000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_exact();
    t_nearest();
    t_directed();
    t_carry();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule